// File: doc/BRIEF.md
# Frame-Sync Serial Converter Port

This block is the device side of a serial port for a data converter whose host is a DSP-style controller. The serial clock runs all the time and chip select may stay low across any number of conversions. Each transaction begins on the falling edge of an input frame-sync pulse. An 8-bit command is then shifted in on falling serial-clock edges. The block picks the channel from the first command bits, opens and closes the acquisition window, and fires a one-clock sample strobe toward the converter core. It then raises an output frame-sync pulse and shifts the converted word out MSB first on rising serial-clock edges.

All logic runs on one system clock. The serial clock, the frame-sync input, chip select, serial data in and the width-select input are synchronised and edge-detected inside the block. The converted value arrives on a parallel input and is captured at the sampling instant. A width-select input chooses between a narrow transaction and a wide one. The wide transaction keeps the acquisition window open for extra serial-clock cycles, and the output frame, the data and the end of the transaction all move later by the same amount.

Top module: `fsp_port`

## Requirements
- R1: The port enters its converter mode only when the frame-sync input is low at the falling edge of chip select. If frame-sync is high at that edge, later frame-sync pulses start nothing: `active_o` and `sdo_o` stay 0 until chip select rises and falls again with frame-sync low.
- R2: After a frame-sync falling edge, serial-clock falling edges 1 to 8 shift `sdi_i` in MSB first. `cmd_o` takes the full 8-bit command at falling edge 8 and holds it across later transactions until the next 8th falling edge. Falling edges 9 and later are ignored.
- R3: At falling edge 3, `chan_o` takes the first three command bits (the first bit received is bit 2 of `chan_o`) and `acq_o` rises.
- R4: `sample_o` is a one-system-clock pulse on rising edge 7 in narrow mode and rising edge 15 in wide mode. `acq_o` falls in the same cycle. The parallel input is captured at that instant.
- R5: `fsync_o` rises on rising edge 8 (narrow) or 16 (wide) and falls on the next rising edge, so it lasts exactly one serial-clock period.
- R6: The 16-bit result word is the 14-bit converter value in bits 15:2, with bits 1:0 zero. It leaves on `sdo_o` MSB first, one bit per rising edge, on edges 9 to 24 (narrow) or 17 to 32 (wide). `sdo_o` is 0 before the first bit.
- R7: After the last result bit, `sdo_o` is 0 on every further rising edge until the next frame sync. `active_o` is high from the frame-sync falling edge through rising edge 24 (narrow) or 32 (wide), so a narrow transaction spans 24 serial clocks.
- R8: The width-select input is sampled at the frame-sync falling edge. When it is high, the acquisition window, the output frame and the data window all move 8 serial clocks later.
- R9: A frame-sync falling edge during a transaction restarts it at once. Edge counts restart from zero, and `acq_o`, `fsync_o` and `sdo_o` drop to 0. `chan_o` and `cmd_o` keep their values until they are recaptured.
- R10: A chip-select rising edge aborts any transaction and leaves converter mode. All outputs return to 0, and frame syncs are ignored until converter mode is entered again.
- R11: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Free-running serial clock (asynchronous) |
| fsync_i | input | 1 | Input frame-sync pulse; falling edge starts a transaction |
| cs_n_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial command data |
| wide_i | input | 1 | Width select: 1 selects the wide transaction |
| conv_data_i | input | DATA_W | Parallel converter value, captured at the sampling instant |
| chan_o | output | CHAN_W | Selected channel |
| cmd_o | output | CMD_W | Last complete command word |
| acq_o | output | 1 | Acquisition window |
| sample_o | output | 1 | One-clock sampling strobe |
| fsync_o | output | 1 | Output frame-sync pulse |
| sdo_o | output | 1 | Serial result data |
| active_o | output | 1 | Transaction in progress |

## Verification
A wrong rising-edge count moves the sample strobe, the output frame or the data window by whole serial-clock periods. The bench compares every output at each serial-clock half period, so such an error shows up at the first misplaced edge. A wrong command shift or channel tap shows on `chan_o` at falling edge 3 and on `cmd_o` at falling edge 8. A wrong mode, abort or restart state gives stray `acq_o`, `active_o` or `sdo_o` activity within one serial-clock half period of the sync or chip-select edge that should have cleared it.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
   // index of each input in the synchroniser bank
   localparam int unsigned SIG_SCLK = 0;
   localparam int unsigned SIG_FS   = 1;
   localparam int unsigned SIG_CS   = 2;
   localparam int unsigned SIG_DIN  = 3;
   localparam int unsigned SIG_WIDE = 4;
   localparam int unsigned SIG_N    = 5;
   // idle levels seen by the bank at reset: chip select and sync high
   localparam logic [SIG_N-1:0] SYNC_INIT = 5'b00110;
endpackage

// File: rtl/fsp_sync_edge.sv
module fsp_sync_edge #(
   parameter int unsigned N      = 5,
   parameter int unsigned STAGES = 2,
   parameter logic [N-1:0] INIT  = '0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fsp_sync_edge: STAGES must be at least 2");
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic              prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= {STAGES{INIT[g]}};
            prev_q  <= INIT[g];
         end else begin
            chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
            prev_q  <= chain_q[STAGES-1];
         end
      end
      assign lvl_o[g]  = chain_q[STAGES-1];
      assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
      assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
   end
endmodule

// File: rtl/fsp_cmd_capture.sv
module fsp_cmd_capture #(
   parameter int unsigned CMD_W   = 8,
   parameter int unsigned CHAN_W  = 3,
   parameter int unsigned CHAN_AT = 3,
   parameter int unsigned IDX_W   = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              shutdown_i,
   input  logic              bit_en_i,
   input  logic              bit_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [CHAN_W-1:0] chan_o,
   output logic [CMD_W-1:0]  cmd_o
);
   logic [CMD_W-1:0]  sh_q;
   logic [CMD_W-1:0]  sh_nx;
   logic [CHAN_W-1:0] chan_q;
   logic [CMD_W-1:0]  cmd_q;

   assign sh_nx = {sh_q[CMD_W-2:0], bit_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         chan_q <= '0;
         cmd_q  <= '0;
      end else if (shutdown_i) begin
         sh_q   <= '0;
         chan_q <= '0;
         cmd_q  <= '0;
      end else if (restart_i) begin
         sh_q   <= '0;
      end else if (bit_en_i) begin
         sh_q <= sh_nx;
         if (idx_i == IDX_W'(CHAN_AT)) chan_q <= sh_nx[CHAN_AT-1 -: CHAN_W];
         if (idx_i == IDX_W'(CMD_W))   cmd_q  <= sh_nx;
      end
   end

   assign chan_o = chan_q;
   assign cmd_o  = cmd_q;
endmodule

// File: rtl/fsp_result_shift.sv
module fsp_result_shift #(
   parameter int unsigned DATA_W       = 14,
   parameter int unsigned WORD_W       = 16,
   parameter bit          LEFT_JUSTIFY = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              shift_i,
   input  logic              zero_i,
   output logic              sdo_o
);
   localparam int unsigned PAD_W = WORD_W - DATA_W;

   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] sreg_q;
   logic              sdo_q;

   if (PAD_W == 0) begin : g_exact
      assign word = data_i;
   end else if (LEFT_JUSTIFY) begin : g_left
      assign word = {data_i, {PAD_W{1'b0}}};
   end else begin : g_right
      assign word = {{PAD_W{1'b0}}, data_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         sdo_q  <= 1'b0;
      end else if (flush_i) begin
         sreg_q <= '0;
         sdo_q  <= 1'b0;
      end else if (load_i) begin
         sreg_q <= word;
      end else if (shift_i) begin
         sdo_q  <= sreg_q[WORD_W-1];
         sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      end else if (zero_i) begin
         sdo_q  <= 1'b0;
      end
   end

   assign sdo_o = sdo_q;
endmodule

// File: rtl/fsp_port.sv
module fsp_port import fsp_pkg::*; #(
   parameter int unsigned DATA_W       = 14,
   parameter int unsigned WORD_W       = 16,
   parameter int unsigned CMD_W        = 8,
   parameter int unsigned CHAN_W       = 3,
   parameter int unsigned CHAN_AT      = 3,
   parameter int unsigned SAMPLE_RISE  = 7,
   parameter int unsigned WIDE_EXTRA   = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          LEFT_JUSTIFY = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              fsync_i,
   input  logic              cs_n_i,
   input  logic              sdi_i,
   input  logic              wide_i,
   input  logic [DATA_W-1:0] conv_data_i,
   output logic [CHAN_W-1:0] chan_o,
   output logic [CMD_W-1:0]  cmd_o,
   output logic              acq_o,
   output logic              sample_o,
   output logic              fsync_o,
   output logic              sdo_o,
   output logic              active_o
);
   localparam int unsigned FSO_N   = SAMPLE_RISE + 1;
   localparam int unsigned FSO_W   = FSO_N + WIDE_EXTRA;
   localparam int unsigned END_N   = FSO_N + WORD_W;
   localparam int unsigned END_W   = FSO_W + WORD_W;
   localparam int unsigned CNT_MAX = END_W + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   if (WORD_W < DATA_W) begin : g_bad_word
      $error("fsp_port: WORD_W must not be below DATA_W");
   end
   if (CHAN_W > CHAN_AT || CHAN_AT > CMD_W || CMD_W < 2) begin : g_bad_cmd
      $error("fsp_port: channel field must fit inside the first command bits");
   end
   if (SAMPLE_RISE <= CHAN_AT) begin : g_bad_sample
      $error("fsp_port: sampling must follow channel selection");
   end

   // ---------------- input synchronisers ----------------
   logic [SIG_N-1:0] lvl, rise, fall;
   fsp_sync_edge #(.N(SIG_N), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  ({wide_i, sdi_i, cs_n_i, fsync_i, sclk_i}),
      .lvl_o  (lvl),
      .rise_o (rise),
      .fall_o (fall)
   );
   logic unused_edges;
   assign unused_edges = ^{lvl[SIG_SCLK], rise[SIG_FS], rise[SIG_DIN], fall[SIG_DIN],
                           rise[SIG_WIDE], fall[SIG_WIDE]};

   // ---------------- sequencer ----------------
   logic             dsp_q, run_q, wide_q, acq_q, fso_q, smp_q;
   logic [CNT_W-1:0] fall_cnt, rise_cnt, fall_nx, rise_nx;
   logic [CNT_W-1:0] smp_at, fso_at, end_at;
   logic             shut, start, tick_f, tick_r, sample_evt, in_win;

   assign shut    = rise[SIG_CS];
   assign start   = dsp_q & fall[SIG_FS] & ~lvl[SIG_CS] & ~shut;
   assign tick_f  = run_q & fall[SIG_SCLK] & ~start & ~shut;
   assign tick_r  = run_q & rise[SIG_SCLK] & ~start & ~shut;
   assign fall_nx = (fall_cnt == CNT_W'(CNT_MAX)) ? fall_cnt : fall_cnt + 1'b1;
   assign rise_nx = (rise_cnt == CNT_W'(CNT_MAX)) ? rise_cnt : rise_cnt + 1'b1;
   assign smp_at  = wide_q ? CNT_W'(SAMPLE_RISE + WIDE_EXTRA) : CNT_W'(SAMPLE_RISE);
   assign fso_at  = wide_q ? CNT_W'(FSO_W) : CNT_W'(FSO_N);
   assign end_at  = wide_q ? CNT_W'(END_W) : CNT_W'(END_N);
   assign sample_evt = tick_r & (rise_nx == smp_at);
   assign in_win     = (rise_nx > fso_at) && (rise_nx <= end_at);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dsp_q    <= 1'b0;
         run_q    <= 1'b0;
         wide_q   <= 1'b0;
         acq_q    <= 1'b0;
         fso_q    <= 1'b0;
         smp_q    <= 1'b0;
         fall_cnt <= '0;
         rise_cnt <= '0;
      end else if (shut) begin
         dsp_q    <= 1'b0;
         run_q    <= 1'b0;
         acq_q    <= 1'b0;
         fso_q    <= 1'b0;
         smp_q    <= 1'b0;
         fall_cnt <= '0;
         rise_cnt <= '0;
      end else begin
         smp_q <= sample_evt;
         if (fall[SIG_CS]) dsp_q <= ~lvl[SIG_FS];
         if (start) begin
            run_q    <= 1'b1;
            wide_q   <= lvl[SIG_WIDE];
            acq_q    <= 1'b0;
            fso_q    <= 1'b0;
            fall_cnt <= '0;
            rise_cnt <= '0;
         end else begin
            if (tick_f) begin
               fall_cnt <= fall_nx;
               if (fall_nx == CNT_W'(CHAN_AT)) acq_q <= 1'b1;
            end
            if (tick_r) begin
               rise_cnt <= rise_nx;
               fso_q    <= (rise_nx == fso_at);
               if (sample_evt) acq_q <= 1'b0;
            end
         end
      end
   end

   // ---------------- datapath ----------------
   fsp_cmd_capture #(.CMD_W(CMD_W), .CHAN_W(CHAN_W), .CHAN_AT(CHAN_AT), .IDX_W(CNT_W)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (start),
      .shutdown_i (shut),
      .bit_en_i   (tick_f && (fall_nx <= CNT_W'(CMD_W))),
      .bit_i      (lvl[SIG_DIN]),
      .idx_i      (fall_nx),
      .chan_o     (chan_o),
      .cmd_o      (cmd_o)
   );

   fsp_result_shift #(.DATA_W(DATA_W), .WORD_W(WORD_W), .LEFT_JUSTIFY(LEFT_JUSTIFY)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (start | shut),
      .load_i  (sample_evt),
      .data_i  (conv_data_i),
      .shift_i (tick_r & in_win),
      .zero_i  (tick_r & ~in_win),
      .sdo_o   (sdo_o)
   );

   assign acq_o    = acq_q;
   assign sample_o = smp_q;
   assign fsync_o  = fso_q;
   assign active_o = run_q & (rise_cnt <= end_at);
endmodule

// File: rtl/fsp_port_chk.sv
module fsp_port_chk (
   input logic clk,
   input logic rst_n,
   input logic acq_o,
   input logic sample_o,
   input logic fsync_o,
   input logic sdo_o,
   input logic active_o
);
   // R4: strobe is a single system-clock pulse
   assert_sample_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |=> !sample_o);
   // R4: the strobe closes an open acquisition window
   assert_sample_ends_acq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |-> ($past(acq_o) && !acq_o));
   // R3: acquisition only inside a transaction
   assert_acq_in_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acq_o |-> active_o);
   // R5: output frame only inside a transaction and after acquisition
   assert_fsync_in_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_o |-> (active_o && !acq_o));
   // R6: no data bit while the output frame pulse is up
   assert_no_data_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_o |-> !sdo_o);
   // R7: line is zero outside the transaction
   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o |-> !sdo_o);
endmodule

bind fsp_port fsp_port_chk u_chk (.*);

// File: tb/fsp_port_bench.sv
`timescale 1ns/1ps
module fsp_port_bench;
   localparam int DATA_W = 14;
   localparam int WORD_W = 16;
   localparam int HALF   = 4;
   localparam int CAP    = 33;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b0, fs = 1'b1, cs_n = 1'b1, din = 1'b0, wide = 1'b0;
   logic [DATA_W-1:0] conv = '0;
   logic [2:0] chan_o;
   logic [7:0] cmd_o;
   logic acq_o, sample_o, fsync_o, sdo_o, active_o;

   fsp_port u_fsp_port (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .fsync_i(fs), .cs_n_i(cs_n),
      .sdi_i(din), .wide_i(wide), .conv_data_i(conv),
      .chan_o(chan_o), .cmd_o(cmd_o), .acq_o(acq_o), .sample_o(sample_o),
      .fsync_o(fsync_o), .sdo_o(sdo_o), .active_o(active_o)
   );

   always #2 clk = ~clk;

   int checks = 0, fails = 0, samp_seen = 0;
   bit done = 1'b0;
   string phase = "";

   // behavioural reference state
   bit m_dsp, m_run, m_wide, m_acq, m_fso, m_sdo, m_act;
   int m_fall, m_rise, m_samp;
   logic [7:0] m_sh, m_cmd;
   logic [2:0] m_chan;
   bit m_q[$];

   always @(negedge clk) if (rst_n && sample_o) samp_seen++;

   task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s [%s] t=%0t: actual %0h expected %0h", req, what, phase, $time, act, exp);
      end
   endtask

   task automatic cmp_all;
      chk("R3", "chan_o",   16'(chan_o),   16'(m_chan));
      chk("R2", "cmd_o",    16'(cmd_o),    16'(m_cmd));
      chk("R3", "acq_o",    16'(acq_o),    16'(m_acq));
      chk("R5", "fsync_o",  16'(fsync_o),  16'(m_fso));
      chk("R6", "sdo_o",    16'(sdo_o),    16'(m_sdo));
      chk("R7", "active_o", 16'(active_o), 16'(m_act));
   endtask

   task automatic settle;
      repeat (HALF) @(negedge clk);
      cmp_all();
   endtask

   task automatic m_shut;
      m_dsp = 0; m_run = 0; m_acq = 0; m_fso = 0; m_sdo = 0; m_act = 0;
      m_chan = '0; m_cmd = '0; m_sh = '0; m_q.delete();
   endtask

   task automatic m_start;
      if (m_dsp && !cs_n) begin
         m_run = 1; m_fall = 0; m_rise = 0; m_wide = wide;
         m_acq = 0; m_fso = 0; m_sdo = 0; m_sh = '0; m_act = 1; m_q.delete();
      end
   endtask

   task automatic m_fall_edge;
      if (m_run) begin
         if (m_fall < CAP) m_fall++;
         if (m_fall <= 8) m_sh = {m_sh[6:0], din};
         if (m_fall == 3) begin m_chan = m_sh[2:0]; m_acq = 1; end
         if (m_fall == 8) m_cmd = m_sh;
      end
   endtask

   task automatic m_rise_edge;
      int sa, fa, ea;
      logic [WORD_W-1:0] w;
      if (m_run) begin
         if (m_rise < CAP) m_rise++;
         sa = m_wide ? 15 : 7;
         fa = sa + 1;
         ea = fa + 16;
         if (m_rise == sa) begin
            m_acq = 0; m_samp++;
            w = {conv, 2'b00};
            m_q.delete();
            for (int i = WORD_W - 1; i >= 0; i--) m_q.push_back(w[i]);
         end
         m_fso = (m_rise == fa);
         if (m_rise > fa && m_rise <= ea && m_q.size() > 0) m_sdo = m_q.pop_front();
         else m_sdo = 0;
         m_act = (m_rise <= ea);
      end
   endtask

   task automatic drv_sclk(input logic v);
      if (sclk && !v) begin sclk = 1'b0; m_fall_edge(); end
      else if (!sclk && v) begin sclk = 1'b1; m_rise_edge(); end
      settle();
   endtask

   task automatic drv_fs(input logic v);
      logic old;
      old = fs; fs = v;
      if (old && !v) m_start();
      settle();
   endtask

   task automatic drv_cs(input logic v);
      logic old;
      old = cs_n; cs_n = v;
      if (old && !v) m_dsp = !fs;
      if (!old && v) m_shut();
      settle();
   endtask

   task automatic tx(input logic [7:0] cmd, input logic wv, input logic [DATA_W-1:0] d, input int n);
      wide = wv; conv = d;
      drv_fs(1'b1);
      drv_fs(1'b0);
      for (int k = 1; k <= n; k++) begin
         din = (k <= 8) ? cmd[8-k] : 1'b0;
         drv_sclk(1'b0);
         drv_sclk(1'b1);
      end
      chk("R4", "sample count", 16'(samp_seen), 16'(m_samp));
   endtask

   initial begin
      m_shut(); m_samp = 0; m_fall = 0; m_rise = 0; m_wide = 0;
      // R11: outputs idle under reset
      phase = "R11 reset";
      repeat (5) @(negedge clk);
      cmp_all();
      rst_n = 1'b1;
      settle();
      drv_sclk(1'b1);

      // R1: enter converter mode with sync low at chip-select fall
      phase = "R1 entry";
      drv_fs(1'b0);
      drv_cs(1'b0);

      // R2 R3 R6 R7: narrow transaction plus trailing clocks that must give zeros
      phase = "R6 narrow";
      tx(8'hA5, 1'b0, 14'h2B3C, 28);
      phase = "R6 narrow ones";
      tx(8'h7F, 1'b0, 14'h3FFF, 26);

      // R8: wide transaction
      phase = "R8 wide";
      tx(8'h5A, 1'b1, 14'h1235, 36);

      // R9: restart mid-conversion, narrow then wide
      phase = "R9 restart narrow";
      tx(8'hC3, 1'b0, 14'h3FF0, 12);
      tx(8'h61, 1'b0, 14'h0AAA, 26);
      phase = "R9 restart wide";
      tx(8'h9E, 1'b1, 14'h1111, 16);
      tx(8'h24, 1'b0, 14'h2001, 25);

      // R10: chip-select rise aborts, syncs then ignored
      phase = "R10 shutdown";
      tx(8'h99, 1'b0, 14'h1555, 5);
      drv_cs(1'b1);
      tx(8'h3C, 1'b0, 14'h0F0F, 10);

      // R1: sync high at chip-select fall leaves port unresponsive
      phase = "R1 not selected";
      drv_fs(1'b1);
      drv_cs(1'b0);
      tx(8'hF0, 1'b0, 14'h00FF, 24);
      drv_cs(1'b1);

      // R1: proper re-entry then a full narrow transaction
      phase = "R1 re-entry";
      drv_fs(1'b0);
      drv_cs(1'b0);
      tx(8'h4B, 1'b0, 14'h2C6D, 27);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end
endmodule